// File: doc/BRIEF.md
# Age-Counter LRU Victim Selector

This block keeps exact least-recently-used order for every set of a set-associative cache. The number of ways and sets are parameters. Each way of each set carries a small age value. Zero means most recently used and the largest value means least recently used. The cache controller reports every access to a way, whether a hit or a fill, through a touch port. When the controller needs a line to replace, it asks through a query port and supplies the valid bits of the addressed set.

The answer is registered and appears one clock after the query. A way that holds no valid line always wins over the least-recently-used way. Among several empty ways, the lowest-numbered one is taken.

Tag and data storage live outside this block. Only the replacement order is kept here.

Top module: `lru_age_picker`

## Requirements
- R1: After reset, way i of every set holds age i. The ages of a set stay a permutation of 0..WAYS-1 at all times, so a query on a freshly reset set with all ways valid returns way WAYS-1.
- R2: A touch of way w in set s sets the age of w to 0. That way becomes the last choice for replacement in s while the set is full.
- R3: A touch raises by one the age of each other way in the set whose age was below the touched way's old age. Ways whose age was above that old value keep it.
- R4: When all valid bits of a query are 1, the reported victim is the way whose age equals WAYS-1.
- R5: When at least one valid bit is 0, the reported victim is a way whose valid bit is 0.
- R6: When several valid bits are 0, the lowest-numbered such way is reported.
- R7: A touch and a query to the same set in one cycle return the victim computed from the ages before that touch.
- R8: While touch_en is low, touch_set and touch_way have no effect on any age.
- R9: A touch changes only the ages of the addressed set.
- R10: vic_vld is high in exactly the cycle after a cycle with query_en high, and low otherwise, including right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_en | input | 1 | An access to a way is reported this cycle |
| touch_set | input | SET_W | Set of the access |
| touch_way | input | IDX_W | Way of the access |
| query_en | input | 1 | Replacement victim requested |
| query_set | input | SET_W | Set of the request |
| query_valid | input | WAYS | Valid bits of the requested set, bit i for way i |
| vic_vld | output | 1 | Victim result valid (one cycle after query_en) |
| vic_way | output | IDX_W | Victim way number |

## Verification
The assertions assume that WAYS and SETS are powers of two, so every set and way code on the ports names a real entry. They also assume that neither enable is raised while rst is high. The bench holds both enables low through reset and draws set and way numbers only from 0..SETS-1 and 0..WAYS-1. Its stimulus mixes directed sequences, where the age order is worked out by hand, with a long random run. That run biases the query set toward the touch set so that same-cycle touch and query pairs occur often. Valid masks are mostly all ones, with a share of random masks that includes the all-zero mask.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
  // width of an index able to name every one of n items (at least one bit)
  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lru_age_store.sv
module lru_age_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int AGE_W = 2,
  parameter int SET_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SET_W-1:0]            rd_a_set,
  output logic [WAYS-1:0][AGE_W-1:0]  rd_a_ages,
  input  logic [SET_W-1:0]            rd_b_set,
  output logic [WAYS-1:0][AGE_W-1:0]  rd_b_ages,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAYS-1:0][AGE_W-1:0]  wr_ages
);
  logic [WAYS-1:0][AGE_W-1:0] age_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_mem[s][w] <= AGE_W'(w);
        end
      end
    end else if (wr_en) begin
      age_mem[wr_set] <= wr_ages;
    end
  end

  assign rd_a_ages = age_mem[rd_a_set];
  assign rd_b_ages = age_mem[rd_b_set];
endmodule

// File: rtl/lru_age_update.sv
module lru_age_update #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  parameter int IDX_W = 2
) (
  input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
  input  logic [IDX_W-1:0]           way_i,
  output logic [WAYS-1:0][AGE_W-1:0] ages_o
);
  logic [AGE_W-1:0] ref_age;

  always_comb begin
    ref_age = ages_i[way_i];
    for (int w = 0; w < WAYS; w++) begin
      if (IDX_W'(w) == way_i) begin
        ages_o[w] = '0;
      end else if (ages_i[w] < ref_age) begin
        ages_o[w] = ages_i[w] + AGE_W'(1);
      end else begin
        ages_o[w] = ages_i[w];
      end
    end
  end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  parameter int IDX_W = 2
) (
  input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
  input  logic [WAYS-1:0]            valid_i,
  output logic [IDX_W-1:0]           way_o
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic             have_empty;
  logic [IDX_W-1:0] empty_way;
  logic [IDX_W-1:0] oldest_way;

  always_comb begin
    have_empty = 1'b0;
    empty_way  = '0;
    // scan downward so that the lowest empty way is the last one kept
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        have_empty = 1'b1;
        empty_way  = IDX_W'(w);
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ages_i[w] == OLDEST) oldest_way = IDX_W'(w);
    end
  end

  assign way_o = have_empty ? empty_way : oldest_way;
endmodule

// File: rtl/lru_age_picker.sv
module lru_age_picker #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int IDX_W = lru_age_pkg::idx_bits(WAYS),
  parameter int SET_W = lru_age_pkg::idx_bits(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              touch_en,
  input  logic [SET_W-1:0]  touch_set,
  input  logic [IDX_W-1:0]  touch_way,
  input  logic              query_en,
  input  logic [SET_W-1:0]  query_set,
  input  logic [WAYS-1:0]   query_valid,
  output logic              vic_vld,
  output logic [IDX_W-1:0]  vic_way
);
  localparam int AGE_W = IDX_W;

  logic [WAYS-1:0][AGE_W-1:0] touch_ages;
  logic [WAYS-1:0][AGE_W-1:0] query_ages;
  logic [WAYS-1:0][AGE_W-1:0] next_ages;
  logic [IDX_W-1:0]           pick_way;

  lru_age_store #(
    .WAYS(WAYS), .SETS(SETS), .AGE_W(AGE_W), .SET_W(SET_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .rd_a_set  (touch_set),
    .rd_a_ages (touch_ages),
    .rd_b_set  (query_set),
    .rd_b_ages (query_ages),
    .wr_en     (touch_en),
    .wr_set    (touch_set),
    .wr_ages   (next_ages)
  );

  lru_age_update #(
    .WAYS(WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)
  ) u_update (
    .ages_i (touch_ages),
    .way_i  (touch_way),
    .ages_o (next_ages)
  );

  lru_victim_pick #(
    .WAYS(WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)
  ) u_pick (
    .ages_i  (query_ages),
    .valid_i (query_valid),
    .way_o   (pick_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_vld <= 1'b0;
      vic_way <= '0;
    end else begin
      vic_vld <= query_en;
      if (query_en) vic_way <= pick_way;
    end
  end
endmodule

// File: rtl/lru_age_picker_chk.sv
module lru_age_picker_chk #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 2,
  parameter int SET_W = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        touch_en,
  input logic [SET_W-1:0]            touch_set,
  input logic [IDX_W-1:0]            touch_way,
  input logic                        query_en,
  input logic [WAYS-1:0]             query_valid,
  input logic [WAYS-1:0][IDX_W-1:0]  touch_ages,
  input logic [WAYS-1:0][IDX_W-1:0]  query_ages,
  input logic                        vic_vld,
  input logic [IDX_W-1:0]            vic_way
);
  logic [WAYS-1:0][IDX_W-1:0] q_ages_d;
  logic [WAYS-1:0]            q_valid_d;
  logic                       q_en_d;
  logic                       t_en_d;
  logic [SET_W-1:0]           t_set_d;
  logic [IDX_W-1:0]           t_way_d;
  logic                       live_d;

  always_ff @(posedge clk) begin
    q_ages_d  <= query_ages;
    q_valid_d <= query_valid;
    q_en_d    <= query_en;
    t_en_d    <= touch_en;
    t_set_d   <= touch_set;
    t_way_d   <= touch_way;
    live_d    <= !rst;
  end

  function automatic logic is_perm(input logic [WAYS-1:0][IDX_W-1:0] a);
    logic [WAYS-1:0] seen;
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[a[w]] = 1'b1;
    return &seen;
  endfunction

  function automatic logic lower_all_valid(input logic [WAYS-1:0] v,
                                           input logic [IDX_W-1:0] k);
    logic ok;
    ok = 1'b1;
    for (int w = 0; w < WAYS; w++) begin
      if (IDX_W'(w) < k && !v[w]) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r1_ages_permutation: assert property (@(posedge clk) disable iff (rst)
    live_d |-> is_perm(query_ages));

  a_r2_touched_is_newest: assert property (@(posedge clk) disable iff (rst)
    (live_d && t_en_d && touch_set == t_set_d) |-> touch_ages[t_way_d] == '0);

  a_r4_full_set_oldest: assert property (@(posedge clk) disable iff (rst)
    (live_d && vic_vld && &q_valid_d) |-> q_ages_d[vic_way] == IDX_W'(WAYS - 1));

  a_r5_empty_way_first: assert property (@(posedge clk) disable iff (rst)
    (live_d && vic_vld && !(&q_valid_d)) |-> !q_valid_d[vic_way]);

  a_r6_lowest_empty: assert property (@(posedge clk) disable iff (rst)
    (live_d && vic_vld && !(&q_valid_d)) |-> lower_all_valid(q_valid_d, vic_way));

  a_r10_vld_follows_query: assert property (@(posedge clk) disable iff (rst)
    live_d |-> (vic_vld == q_en_d));
endmodule

bind lru_age_picker lru_age_picker_chk #(
  .WAYS(WAYS), .IDX_W(IDX_W), .SET_W(SET_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .touch_en    (touch_en),
  .touch_set   (touch_set),
  .touch_way   (touch_way),
  .query_en    (query_en),
  .query_valid (query_valid),
  .touch_ages  (touch_ages),
  .query_ages  (query_ages),
  .vic_vld     (vic_vld),
  .vic_way     (vic_way)
);

// File: tb/sim_lru_age_picker.sv
`timescale 1ns/100ps
module sim_lru_age_picker;
  localparam int W     = 4;
  localparam int S     = 16;
  localparam int IDX_W = 2;
  localparam int SET_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             touch_en = 1'b0;
  logic [SET_W-1:0] touch_set = '0;
  logic [IDX_W-1:0] touch_way = '0;
  logic             query_en = 1'b0;
  logic [SET_W-1:0] query_set = '0;
  logic [W-1:0]     query_valid = '1;
  logic             vic_vld;
  logic [IDX_W-1:0] vic_way;

  always #2.5 clk = ~clk;

  lru_age_picker #(.WAYS(W), .SETS(S)) u0 (
    .clk(clk), .rst(rst),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
    .query_en(query_en), .query_set(query_set), .query_valid(query_valid),
    .vic_vld(vic_vld), .vic_way(vic_way)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  int    ref_age [S][W];
  int    exp_q [$];
  string tag_q [$];

  function automatic int ref_victim(int s, logic [W-1:0] v);
    for (int w = 0; w < W; w++) if (!v[w]) return w;
    for (int w = 0; w < W; w++) if (ref_age[s][w] == W - 1) return w;
    return -1;
  endfunction

  function automatic void ref_touch(int s, int way);
    int old;
    old = ref_age[s][way];
    for (int w = 0; w < W; w++) begin
      if (w == way) ref_age[s][w] = 0;
      else if (ref_age[s][w] < old) ref_age[s][w] = ref_age[s][w] + 1;
    end
  endfunction

  task automatic cyc(bit te, int ts, int tw, bit qe, int qs,
                     logic [W-1:0] qv, string tag);
    @(negedge clk);
    touch_en    = te;
    touch_set   = SET_W'(ts);
    touch_way   = IDX_W'(tw);
    query_en    = qe;
    query_set   = SET_W'(qs);
    query_valid = qv;
    if (qe) begin
      exp_q.push_back(ref_victim(qs, qv));   // pre-touch state (R7)
      tag_q.push_back(tag);
    end
    if (te) ref_touch(ts, tw);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, '1, "");
  endtask

  // monitor: compares each result one edge after its query
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (vic_vld) begin
          n_chk++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10: vic_vld got 1 exp 0");
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (int'(vic_way) != e) begin
              n_bad++;
              $display("FAIL %s: vic_way got %0d exp %0d", t, vic_way, e);
            end
          end
        end else if (exp_q.size() != 0) begin
          string t;
          n_chk++;
          n_bad++;
          void'(exp_q.pop_front());
          t = tag_q.pop_front();
          $display("FAIL R10 (%s): vic_vld got 0 exp 1", t);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run got hung exp finished");
    finish_run();
  end

  initial begin
    for (int s = 0; s < S; s++)
      for (int w = 0; w < W; w++) ref_age[s][w] = w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (vic_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: vic_vld after reset got %b exp 0", vic_vld);
    end
    // R1: every set starts with way W-1 oldest
    for (int s = 0; s < S; s++) cyc(0, 0, 0, 1, s, '1, "R1");
    idle();
    // R8: disabled touch changes nothing
    cyc(0, 1, 3, 0, 0, '1, "R8");
    cyc(0, 1, 3, 1, 1, '1, "R8");
    // R9: touching set 2 leaves set 3 untouched
    cyc(1, 2, 3, 0, 0, '1, "R9");
    cyc(0, 0, 0, 1, 3, '1, "R9");
    cyc(0, 0, 0, 1, 2, '1, "R9");
    // R3: ages 0,1,2,3; touch 2 -> 1,2,0,3 ; touch 3 -> 2,3,1,0
    cyc(1, 7, 2, 0, 0, '1, "R3");
    cyc(0, 0, 0, 1, 7, '1, "R3");
    cyc(1, 7, 3, 0, 0, '1, "R3");
    cyc(0, 0, 0, 1, 7, '1, "R3");
    // R2: touched way becomes newest
    cyc(1, 6, 0, 0, 0, '1, "R2");
    cyc(1, 6, 1, 0, 0, '1, "R2");
    cyc(1, 6, 2, 0, 0, '1, "R2");
    cyc(0, 0, 0, 1, 6, '1, "R2");
    cyc(1, 6, 3, 0, 0, '1, "R2");
    cyc(0, 0, 0, 1, 6, '1, "R2");
    // R4: full set picks the oldest after a reordering
    cyc(1, 5, 1, 0, 0, '1, "R4");
    cyc(1, 5, 3, 0, 0, '1, "R4");
    cyc(0, 0, 0, 1, 5, '1, "R4");
    // R5 / R6: empty ways first, lowest empty wins
    cyc(0, 0, 0, 1, 5, 4'b1011, "R5");
    cyc(0, 0, 0, 1, 5, 4'b0111, "R5");
    cyc(0, 0, 0, 1, 5, 4'b0101, "R6");
    cyc(0, 0, 0, 1, 5, 4'b0000, "R6");
    cyc(0, 0, 0, 1, 5, 4'b1100, "R6");
    // R7: same-cycle touch and query see the old order
    cyc(1, 4, 3, 1, 4, '1, "R7");
    cyc(0, 0, 0, 1, 4, '1, "R7");
    // back-to-back queries (R10)
    cyc(0, 0, 0, 1, 9, '1, "R10");
    cyc(0, 0, 0, 1, 10, '1, "R10");
    idle();
    // random mix covering R1..R7
    for (int i = 0; i < 4000; i++) begin
      int           ts, qs;
      logic [W-1:0] qv;
      ts = $urandom_range(0, S - 1);
      qs = ($urandom_range(0, 2) == 0) ? ts : $urandom_range(0, S - 1);
      qv = ($urandom_range(0, 3) == 0) ? W'($urandom) : '1;
      cyc(1'($urandom_range(0, 1)), ts, $urandom_range(0, W - 1),
          1'($urandom_range(0, 1)), qs, qv, "R4/R5/R7 random");
    end
    idle();
    idle();
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: pending results got %0d exp 0", exp_q.size());
    end
    finish_run();
  end
endmodule